// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Angle Input Register

This block takes a 16-bit binary angle from one parallel data bus shared by two channels, A and B, and holds a stable copy of it for each channel's downstream converter. Each channel has a first rank made of two separately enabled byte registers, one for the upper byte and one for the lower byte. Software can therefore build a full angle from two byte writes. A second rank, controlled by a per-channel load enable, copies the assembled word into a holding register whose output drives the converter. The channels share only the data bus. Every enable, every register and the gain decode are separate for each channel.

Each rank behaves like a level-sensitive latch, sampled on the clock. While its enable is high, a rank copies its input on every clock. While the enable is low, it keeps its value. Each enable input comes with a "driven" qualifier. When the qualifier is low, that enable counts as high, so a channel whose controls are all undriven passes the bus straight through to its output. The block also turns two gain-select pins per channel into a gain code.

Top module: `dual_angle_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both ranks of both channels, so `angle_a` and `angle_b` read 0 after that edge, whatever the enables are doing.
- R2: On each clock edge where a channel's effective upper enable is high, its upper first-rank byte takes `bus_data[15:8]`. Bit 15 is the most significant angle bit and weighs 180 degrees. While the enable is low, the byte holds its value.
- R3: On each clock edge where a channel's effective lower enable is high, its lower first-rank byte takes `bus_data[7:0]`. Bit 0 is the least significant bit and weighs about 0.0055 degrees. While the enable is low, the byte holds its value.
- R4: On each clock edge where a channel's effective load enable is high, its holding register takes {upper byte, lower byte} as they stood before that edge. While the load enable is low, the channel's angle output does not change, even if the first rank does.
- R5: With all three enables of a channel high, a new bus value first shows on the channel's angle output after the second clock edge. After the first edge the output still shows the previous first-rank word.
- R6: An enable whose driven qualifier is 0 acts as high, whatever its own level. With all qualifiers 0, a channel is fully transparent.
- R7: Index 0 of every per-channel input belongs to channel A and index 1 to channel B. The controls of one channel never change the other channel's angle output.
- R8: Gain pins read 1 for grounded and 0 for open. GC1 grounded with GC2 open gives gain code 0 (gain 0.5). Both open gives code 1 (gain 1.0). GC1 open with GC2 grounded gives code 2 (gain 2.0). The invalid flag is 0 in all three cases.
- R9: With both gain pins of a channel grounded, the channel's invalid flag is 1 and its gain code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 16 | Shared angle data bus, natural binary |
| hi_en | input | 2 | Upper-byte enable per channel ([0]=A, [1]=B) |
| hi_en_drv | input | 2 | Driven qualifier for hi_en; 0 forces the enable high |
| lo_en | input | 2 | Lower-byte enable per channel |
| lo_en_drv | input | 2 | Driven qualifier for lo_en |
| ld_en | input | 2 | Holding-register load enable per channel |
| ld_en_drv | input | 2 | Driven qualifier for ld_en |
| gc1_gnd | input | 2 | Gain pin 1 per channel, 1 = grounded |
| gc2_gnd | input | 2 | Gain pin 2 per channel, 1 = grounded |
| angle_a | output | 16 | Channel A held angle |
| angle_b | output | 16 | Channel B held angle |
| gain_a | output | 2 | Channel A gain code |
| gain_b | output | 2 | Channel B gain code |
| gain_bad_a | output | 1 | Channel A invalid gain-pin combination |
| gain_bad_b | output | 1 | Channel B invalid gain-pin combination |

## Verification
The first-rank capture and the second-rank transfer can happen on the same clock edge. In that case the holding register must take the first-rank word as it stood before the edge, not the bus value being captured at that edge. The bench sets up this collision by raising the byte enables and the load enable of one channel together for a single cycle while a new value sits on the bus. It then checks that the angle output shows the previous first-rank word after that edge, and shows the new value only after a further load.

// File: rtl/dual_angle_pkg.sv
package dual_angle_pkg;
    localparam int NUM_CH  = 2;
    localparam int ANGLE_W = 16;
    localparam int BYTE_W  = ANGLE_W / 2;
    localparam int GAIN_W  = 2;

    typedef enum logic [GAIN_W-1:0] {
        GAIN_HALF   = 2'd0,
        GAIN_UNITY  = 2'd1,
        GAIN_DOUBLE = 2'd2
    } gain_code_e;
endpackage

// File: rtl/en_resolve.sv
// Turns raw enables plus "driven" qualifiers into effective enables:
// an undriven enable is treated as asserted.
module en_resolve #(
    parameter int N = 6
) (
    input  logic [N-1:0] en_raw,
    input  logic [N-1:0] en_drv,
    output logic [N-1:0] en_eff
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb en_eff[i] = en_raw[i] | ~en_drv[i];
    end
endmodule

// File: rtl/chan_rank.sv
// One channel: split first rank (upper/lower byte) and a second-rank
// holding register, each a clock-sampled level-transparent register.
module chan_rank #(
    parameter int WORD_W = 16,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] bus_in,
    input  logic              hi_eff,
    input  logic              lo_eff,
    input  logic              ld_eff,
    output logic [HALF_W-1:0] hi_byte,
    output logic [HALF_W-1:0] lo_byte,
    output logic [WORD_W-1:0] hold_word
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [WORD_W-1:0] hold;
    } rank_state_t;

    rank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hi_eff) begin
            st_d.hi = bus_in[WORD_W-1:HALF_W];
        end
        if (lo_eff) begin
            st_d.lo = bus_in[HALF_W-1:0];
        end
        if (ld_eff) begin
            // second rank sees the first rank as it was before this edge
            st_d.hold = {st_q.hi, st_q.lo};
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hi_byte   = st_q.hi;
    assign lo_byte   = st_q.lo;
    assign hold_word = st_q.hold;
endmodule

// File: rtl/gain_decode.sv
// Decodes two grounded/open gain pins into a gain code.
module gain_decode
    import dual_angle_pkg::*;
(
    input  logic              g1_gnd,
    input  logic              g2_gnd,
    output logic [GAIN_W-1:0] code,
    output logic              bad
);
    gain_code_e code_d;

    always_comb begin
        bad    = 1'b0;
        code_d = GAIN_UNITY;
        unique case ({g1_gnd, g2_gnd})
            2'b10:   code_d = GAIN_HALF;
            2'b00:   code_d = GAIN_UNITY;
            2'b01:   code_d = GAIN_DOUBLE;
            default: begin
                code_d = GAIN_UNITY;
                bad    = 1'b1;
            end
        endcase
    end

    assign code = code_d;
endmodule

// File: rtl/dual_angle_latch.sv
module dual_angle_latch
    import dual_angle_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] bus_data,
    input  logic [NUM_CH-1:0]  hi_en,
    input  logic [NUM_CH-1:0]  hi_en_drv,
    input  logic [NUM_CH-1:0]  lo_en,
    input  logic [NUM_CH-1:0]  lo_en_drv,
    input  logic [NUM_CH-1:0]  ld_en,
    input  logic [NUM_CH-1:0]  ld_en_drv,
    input  logic [NUM_CH-1:0]  gc1_gnd,
    input  logic [NUM_CH-1:0]  gc2_gnd,
    output logic [ANGLE_W-1:0] angle_a,
    output logic [ANGLE_W-1:0] angle_b,
    output logic [GAIN_W-1:0]  gain_a,
    output logic [GAIN_W-1:0]  gain_b,
    output logic               gain_bad_a,
    output logic               gain_bad_b
);
    localparam int EN_N = 3 * NUM_CH;

    logic [EN_N-1:0] en_eff;
    logic [NUM_CH-1:0][BYTE_W-1:0]  r1_hi;
    logic [NUM_CH-1:0][BYTE_W-1:0]  r1_lo;
    logic [NUM_CH-1:0][ANGLE_W-1:0] r2_q;
    logic [NUM_CH-1:0][GAIN_W-1:0]  gain_code;
    logic [NUM_CH-1:0]              gain_bad;

    en_resolve #(.N(EN_N)) u_en (
        .en_raw ({ld_en, lo_en, hi_en}),
        .en_drv ({ld_en_drv, lo_en_drv, hi_en_drv}),
        .en_eff (en_eff)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_rank #(.WORD_W(ANGLE_W)) u_rank (
            .clk       (clk),
            .rst       (rst),
            .bus_in    (bus_data),
            .hi_eff    (en_eff[c]),
            .lo_eff    (en_eff[NUM_CH + c]),
            .ld_eff    (en_eff[2*NUM_CH + c]),
            .hi_byte   (r1_hi[c]),
            .lo_byte   (r1_lo[c]),
            .hold_word (r2_q[c])
        );

        gain_decode u_gain (
            .g1_gnd (gc1_gnd[c]),
            .g2_gnd (gc2_gnd[c]),
            .code   (gain_code[c]),
            .bad    (gain_bad[c])
        );
    end

    assign angle_a    = r2_q[0];
    assign angle_b    = r2_q[1];
    assign gain_a     = gain_code[0];
    assign gain_b     = gain_code[1];
    assign gain_bad_a = gain_bad[0];
    assign gain_bad_b = gain_bad[1];
endmodule

// File: rtl/dual_angle_latch_chk.sv
module dual_angle_latch_chk
    import dual_angle_pkg::*;
(
    input logic                           clk,
    input logic                           rst,
    input logic [ANGLE_W-1:0]             bus_data,
    input logic [NUM_CH-1:0]              hi_en,
    input logic [NUM_CH-1:0]              hi_en_drv,
    input logic [NUM_CH-1:0]              lo_en,
    input logic [NUM_CH-1:0]              lo_en_drv,
    input logic [NUM_CH-1:0]              ld_en,
    input logic [NUM_CH-1:0]              ld_en_drv,
    input logic [NUM_CH-1:0]              gc1_gnd,
    input logic [NUM_CH-1:0]              gc2_gnd,
    input logic [NUM_CH-1:0][BYTE_W-1:0]  r1_hi,
    input logic [NUM_CH-1:0][BYTE_W-1:0]  r1_lo,
    input logic [NUM_CH-1:0][ANGLE_W-1:0] r2_q,
    input logic [NUM_CH-1:0][GAIN_W-1:0]  gain_code,
    input logic [NUM_CH-1:0]              gain_bad
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_reset_clears_R1: assert property (@(posedge clk)
            rst |=> (r2_q[c] == '0 && r1_hi[c] == '0 && r1_lo[c] == '0));

        assert_hi_capture_R2: assert property (@(posedge clk) disable iff (rst)
            (hi_en[c] || !hi_en_drv[c]) |=> r1_hi[c] == $past(bus_data[ANGLE_W-1:BYTE_W]));

        assert_hi_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (!hi_en[c] && hi_en_drv[c]) |=> $stable(r1_hi[c]));

        assert_lo_capture_R3: assert property (@(posedge clk) disable iff (rst)
            (lo_en[c] || !lo_en_drv[c]) |=> r1_lo[c] == $past(bus_data[BYTE_W-1:0]));

        assert_lo_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!lo_en[c] && lo_en_drv[c]) |=> $stable(r1_lo[c]));

        assert_load_old_rank_R4: assert property (@(posedge clk) disable iff (rst)
            (ld_en[c] || !ld_en_drv[c]) |=> r2_q[c] == $past({r1_hi[c], r1_lo[c]}));

        assert_load_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (!ld_en[c] && ld_en_drv[c]) |=> $stable(r2_q[c]));

        assert_gain_valid_R8: assert property (@(posedge clk) disable iff (rst)
            (gc1_gnd[c] != gc2_gnd[c]) |-> (!gain_bad[c] && gain_code[c] == (gc1_gnd[c] ? 2'd0 : 2'd2)));

        assert_gain_invalid_R9: assert property (@(posedge clk) disable iff (rst)
            (gc1_gnd[c] && gc2_gnd[c]) |-> (gain_bad[c] && gain_code[c] == 2'd1));
    end
endmodule

bind dual_angle_latch dual_angle_latch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_data  (bus_data),
    .hi_en     (hi_en),
    .hi_en_drv (hi_en_drv),
    .lo_en     (lo_en),
    .lo_en_drv (lo_en_drv),
    .ld_en     (ld_en),
    .ld_en_drv (ld_en_drv),
    .gc1_gnd   (gc1_gnd),
    .gc2_gnd   (gc2_gnd),
    .r1_hi     (r1_hi),
    .r1_lo     (r1_lo),
    .r2_q      (r2_q),
    .gain_code (gain_code),
    .gain_bad  (gain_bad)
);

// File: tb/dual_angle_latch_bench.sv
`timescale 1ns/1ps
module dual_angle_latch_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_data;
    logic [1:0]  hi_en, hi_en_drv, lo_en, lo_en_drv, ld_en, ld_en_drv;
    logic [1:0]  gc1_gnd, gc2_gnd;
    logic [15:0] angle_a, angle_b;
    logic [1:0]  gain_a, gain_b;
    logic        gain_bad_a, gain_bad_b;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dual_angle_latch u_dual_angle_latch (
        .clk(clk), .rst(rst), .bus_data(bus_data),
        .hi_en(hi_en), .hi_en_drv(hi_en_drv),
        .lo_en(lo_en), .lo_en_drv(lo_en_drv),
        .ld_en(ld_en), .ld_en_drv(ld_en_drv),
        .gc1_gnd(gc1_gnd), .gc2_gnd(gc2_gnd),
        .angle_a(angle_a), .angle_b(angle_b),
        .gain_a(gain_a), .gain_b(gain_b),
        .gain_bad_a(gain_bad_a), .gain_bad_b(gain_bad_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic all_low();
        hi_en = 2'b00; lo_en = 2'b00; ld_en = 2'b00;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] keep_b;
        rst = 1'b1;
        bus_data = 16'hBEEF;
        hi_en = 2'b11; lo_en = 2'b11; ld_en = 2'b11;
        hi_en_drv = 2'b11; lo_en_drv = 2'b11; ld_en_drv = 2'b11;
        gc1_gnd = 2'b00; gc2_gnd = 2'b00;
        tick(3);
        // R1: reset dominates enables
        chk("R1 reset A", angle_a, 0);
        chk("R1 reset B", angle_b, 0);
        rst = 1'b0;
        all_low();
        tick(1);
        chk("R1 enables low after reset B", angle_b, 0);

        // R2/R3/R4/R7 sweep on channel A, channel B held
        for (int i = 0; i < 64; i++) begin
            logic [15:0] v;
            v = {8'(i * 37 + 1), 8'(255 - i * 3)};
            bus_data = v; hi_en[0] = 1'b1; lo_en[0] = 1'b1;
            tick(1);
            all_low(); bus_data = ~v; ld_en[0] = 1'b1;
            tick(1);
            ld_en[0] = 1'b0;
            chk("R2 R3 sweep A", angle_a, v);
            chk("R7 B untouched", angle_b, 0);
        end

        // R2/R3: bytes written separately
        bus_data = 16'h1234; hi_en[0] = 1'b1; tick(1); all_low();
        bus_data = 16'hABCD; lo_en[0] = 1'b1; tick(1); all_low();
        bus_data = 16'hFFFF; tick(1);
        ld_en[0] = 1'b1; tick(1); all_low();
        chk("R2 R3 split bytes", angle_a, 16'h12CD);

        // R4: first rank changes, load low -> output holds
        bus_data = 16'h5555; hi_en[0] = 1'b1; lo_en[0] = 1'b1; tick(1); all_low();
        tick(2);
        chk("R4 hold while load low", angle_a, 16'h12CD);
        ld_en[0] = 1'b1; tick(1); all_low();
        chk("R4 load after hold", angle_a, 16'h5555);

        // R4: capture and transfer in the same edge
        bus_data = 16'h9999; hi_en[0] = 1'b1; lo_en[0] = 1'b1; ld_en[0] = 1'b1;
        tick(1); all_low();
        chk("R4 same-edge takes old rank", angle_a, 16'h5555);
        ld_en[0] = 1'b1; tick(1); all_low();
        chk("R4 then new word", angle_a, 16'h9999);

        // R5: channel B all enables high, two-edge latency
        hi_en[1] = 1'b1; lo_en[1] = 1'b1; ld_en[1] = 1'b1;
        bus_data = 16'h0F1E; tick(2);
        chk("R5 settle B", angle_b, 16'h0F1E);
        bus_data = 16'hC3A5; tick(1);
        chk("R5 first edge old", angle_b, 16'h0F1E);
        tick(1);
        chk("R5 second edge new", angle_b, 16'hC3A5);
        chk("R7 A untouched by B", angle_a, 16'h9999);
        all_low();
        keep_b = 16'hC3A5;

        // R6: undriven enables on channel A force transparency
        hi_en_drv[0] = 1'b0; lo_en_drv[0] = 1'b0; ld_en_drv[0] = 1'b0;
        bus_data = 16'h7E81; tick(2);
        chk("R6 undriven transparent A", angle_a, 16'h7E81);
        chk("R7 B holds", angle_b, keep_b);
        // R6: one undriven enable alone
        hi_en_drv[0] = 1'b1; lo_en_drv[0] = 1'b1;
        bus_data = 16'h0000; tick(1);
        ld_en_drv[0] = 1'b1; tick(1);
        chk("R6 only load undriven", angle_a, 16'h7E81);
        hi_en_drv[0] = 1'b0; bus_data = 16'h4200; tick(1);
        hi_en_drv[0] = 1'b1; ld_en[0] = 1'b1; tick(1); all_low();
        chk("R6 undriven hi byte", angle_a, 16'h4281);

        // R8/R9: exhaustive gain pins for both channels
        for (int c = 0; c < 2; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [1:0] ec;
                logic eb;
                gc1_gnd[c] = p[0]; gc2_gnd[c] = p[1];
                #1;
                ec = (p == 1) ? 2'd0 : (p == 2) ? 2'd2 : 2'd1;
                eb = (p == 3);
                if (c == 0) begin
                    chk(eb ? "R9 gain A" : "R8 gain A", {gain_bad_a, gain_a}, {eb, ec});
                end else begin
                    chk(eb ? "R9 gain B" : "R8 gain B", {gain_bad_b, gain_b}, {eb, ec});
                end
            end
            gc1_gnd[c] = 1'b0; gc2_gnd[c] = 1'b0;
        end

        // R1: reset mid-run clears both channels
        tick(1);
        rst = 1'b1; hi_en = 2'b11; lo_en = 2'b11; ld_en = 2'b11;
        tick(1);
        chk("R1 mid reset A", angle_a, 0);
        chk("R1 mid reset B", angle_b, 0);
        rst = 1'b0; all_low(); tick(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule